// File: doc/BRIEF.md
# Configuration Space Key-Gated Index/Data Port

This block is a slave on a byte-wide I/O bus. It exposes a protected configuration space through two adjacent ports: an index port at the strapped base address and a data port at base+1. The space stays locked until the host writes the unlock byte to the index port on two consecutive index writes. Once it is open, the host writes a register number to the index port and then reads or writes that register through the data port. Writing the lock byte to the index port closes the space again.

Inside the space the block holds a logical-device select register and a set of read-only identification registers. These are a 16-bit device ID, a revision byte and a 16-bit manufacturer ID, and each 16-bit value reads high byte first. Indices 0x80 to 0xFF are passed to an external GPIO register bank, but only while logical device 0x06 is selected.

The bus has no stall. A strobe completes in the cycle it is asserted, and read data is combinational from the current address. The block applies no back-pressure, and neither does the bank port: bank read data must be valid in the same cycle as `bank_rd`.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, the selected logical device is 0x00 and the index is 0x00. A read of either port at the base address returns 0xFF.
- R2: The space opens only after 0x87 is written to the index port on two consecutive index-port writes. A single 0x87 leaves it locked.
- R3: After one 0x87, an index-port write of any other byte returns the key sequence to its start, so a fresh pair of 0x87 writes is needed.
- R4: While open, writing 0xAA to the index port locks the space. That write does not change the stored index.
- R5: While locked, data-port reads return 0xFF. Data-port writes and non-key index writes change no state and raise no bank strobe.
- R6: While open, index 0x20 reads the device ID high byte and 0x21 its low byte, 0x22 reads the revision, and 0x23/0x24 read the manufacturer ID 0x1934 (high byte, then low byte).
- R7: The identification registers are read-only. Data-port writes to them change nothing.
- R8: Index 0x07 holds the logical-device number and is readable and writable through the data port while open.
- R9: With device 0x06 selected, a data access at an index of 0x80 or above strobes `bank_wr`/`bank_rd`, with `bank_addr` set to the index's low 7 bits, and a read returns `bank_rdata`. With any other device selected, no strobe is raised and such reads return 0xFF.
- R10: The ports decode only at the strapped base (0x2E by default, 0x4E when `ALT_BASE`=1) and base+1. Accesses at other addresses are ignored and read 0xFF.
- R11: While open, an index-port read returns the stored index. While locked it returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| bank_addr | output | 7 | GPIO bank register offset (index minus 0x80) |
| bank_wr | output | 1 | GPIO bank write strobe |
| bank_rd | output | 1 | GPIO bank read strobe |
| bank_wdata | output | 8 | GPIO bank write data |
| bank_rdata | input | 8 | GPIO bank read data, valid in the strobe cycle |

## Verification
The hardest case to reach from the ports is a broken key pair. The half-unlocked state has no visible output, so it is observed only through what it allows next. The bench drives 0x87, then another index byte, then 0x87 once more, and then tries a register read, which must still return 0xFF. A second hidden condition is that locked writes must not disturb the stored device number. This is shown by writing the data port while the space is locked, reopening it, and reading index 0x07 back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {KEY_LOCKED, KEY_HALF, KEY_OPEN} key_state_e;

  localparam logic [7:0] KEY_UNLOCK   = 8'h87;
  localparam logic [7:0] KEY_LOCK     = 8'hAA;
  localparam logic [7:0] IDX_LDN      = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_MFR_HI   = 8'h23;
  localparam logic [7:0] IDX_MFR_LO   = 8'h24;
  localparam logic [7:0] IDLE_BYTE    = 8'hFF;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (wdata == KEY_UNLOCK) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_d = (wdata == KEY_UNLOCK) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   state_d = (wdata == KEY_LOCK)   ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KEY_LOCKED;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == KEY_OPEN);

  // R2: opening is always caused by an unlock byte on the index port
  a_r2_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(idx_wr && wdata == KEY_UNLOCK));

  // R4: the lock byte closes an open space
  a_r4_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == KEY_LOCK) |=> !cfg_open);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID   = 16'hB51C,
  parameter logic [7:0]  DEV_REV  = 8'h03,
  parameter logic [15:0] MFR_ID   = 16'h1934,
  parameter logic [7:0]  GPIO_LDN = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] bank_rdata,
  output logic [7:0] index_q,
  output logic [7:0] cfg_rdata,
  output logic [6:0] bank_addr,
  output logic       bank_wr,
  output logic       bank_rd
);
  logic [7:0] ldn_q;
  logic       gpio_route;
  logic       ldn_we;

  assign ldn_we     = cfg_open && dat_wr && (index_q == IDX_LDN);
  assign gpio_route = cfg_open && (ldn_q == GPIO_LDN) && index_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (cfg_open && idx_wr && wdata != KEY_LOCK) index_q <= wdata;
      if (ldn_we) ldn_q <= wdata;
    end
  end

  assign bank_addr = index_q[6:0];
  assign bank_wr   = gpio_route && dat_wr;
  assign bank_rd   = gpio_route && dat_rd;

  always_comb begin
    cfg_rdata = IDLE_BYTE;
    if (cfg_open) begin
      if (gpio_route) cfg_rdata = bank_rdata;
      else begin
        unique case (index_q)
          IDX_LDN:      cfg_rdata = ldn_q;
          IDX_DEVID_HI: cfg_rdata = DEV_ID[15:8];
          IDX_DEVID_LO: cfg_rdata = DEV_ID[7:0];
          IDX_REV:      cfg_rdata = DEV_REV;
          IDX_MFR_HI:   cfg_rdata = MFR_ID[15:8];
          IDX_MFR_LO:   cfg_rdata = MFR_ID[7:0];
          default:      cfg_rdata = IDLE_BYTE;
        endcase
      end
    end
  end

  // R5/R8: the device number moves only on an open data write to index 0x07
  a_r8_ldn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_open && dat_wr && index_q == IDX_LDN) |=> $stable(ldn_q));

  // R9: bank strobes only with the GPIO device selected
  a_r9_bank_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |-> (ldn_q == GPIO_LDN && cfg_open));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter bit          ALT_BASE = 1'b0,
  parameter logic [15:0] DEV_ID   = 16'hB51C,
  parameter logic [7:0]  DEV_REV  = 8'h03,
  parameter logic [15:0] MFR_ID   = 16'h1934,
  parameter logic [7:0]  GPIO_LDN = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [6:0]        bank_addr,
  output logic              bank_wr,
  output logic              bank_rd,
  output logic [7:0]        bank_wdata,
  input  logic [7:0]        bank_rdata
);
  localparam logic [ADDR_W-1:0] BASE_ADDR =
    ALT_BASE ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic hit_idx, hit_dat, cfg_open;
  logic [7:0] index_q, cfg_rdata;

  assign hit_idx = (io_addr == BASE_ADDR);
  assign hit_dat = (io_addr == DATA_ADDR);

  sio_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (io_wr && hit_idx),
    .wdata    (io_wdata),
    .cfg_open (cfg_open)
  );

  sio_cfg_regs #(
    .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MFR_ID(MFR_ID), .GPIO_LDN(GPIO_LDN)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_open   (cfg_open),
    .idx_wr     (io_wr && hit_idx),
    .dat_wr     (io_wr && hit_dat),
    .dat_rd     (io_rd && hit_dat),
    .wdata      (io_wdata),
    .bank_rdata (bank_rdata),
    .index_q    (index_q),
    .cfg_rdata  (cfg_rdata),
    .bank_addr  (bank_addr),
    .bank_wr    (bank_wr),
    .bank_rd    (bank_rd)
  );

  assign bank_wdata = io_wdata;

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (hit_idx)      io_rdata = cfg_open ? index_q : IDLE_BYTE;
    else if (hit_dat) io_rdata = cfg_rdata;
  end

  // R5: locked data reads float high
  a_r5_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd && hit_dat) |-> io_rdata == IDLE_BYTE);

  // R10: nothing reaches the bank from an address outside the port pair
  a_r10_no_foreign_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |-> hit_dat);
endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata, bank_wdata, bank_rdata;
  logic [6:0]  bank_addr;
  logic        bank_wr, bank_rd;

  int errors = 0, checks = 0;
  int bank_wr_cnt = 0;
  logic [6:0] last_baddr = 7'h0;
  logic [7:0] last_bdata = 8'h0;
  logic [7:0] rd;

  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  always #10 clk = ~clk; // 50 MHz

  sio_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bank_addr(bank_addr),
    .bank_wr(bank_wr), .bank_rd(bank_rd), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata)
  );

  // GPIO bank model: read data derived from the offset
  assign bank_rdata = {1'b0, bank_addr} ^ 8'h5A;

  always @(posedge clk) if (bank_wr) begin
    bank_wr_cnt <= bank_wr_cnt + 1;
    last_baddr  <= bank_addr;
    last_bdata  <= bank_wdata;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rdp(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  // op: 0 index write, 1 data write, 2 data read check, 3 index read check
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;
  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h87, 4'd2}, '{2'd0, 8'h87, 4'd2},          // R2 unlock pair
    '{2'd0, 8'h20, 4'd6}, '{2'd2, 8'hB5, 4'd6},          // R6 device ID high
    '{2'd0, 8'h21, 4'd6}, '{2'd2, 8'h1C, 4'd6},
    '{2'd0, 8'h22, 4'd6}, '{2'd2, 8'h03, 4'd6},
    '{2'd0, 8'h23, 4'd6}, '{2'd2, 8'h19, 4'd6},
    '{2'd0, 8'h24, 4'd6}, '{2'd2, 8'h34, 4'd6},
    '{2'd0, 8'h20, 4'd7}, '{2'd1, 8'h00, 4'd7},          // R7 write ignored
    '{2'd2, 8'hB5, 4'd7},
    '{2'd0, 8'h07, 4'd8}, '{2'd2, 8'h00, 4'd8},          // R8 select register
    '{2'd1, 8'h06, 4'd8}, '{2'd2, 8'h06, 4'd8},
    '{2'd3, 8'h07, 4'd11},                               // R11 index readback
    '{2'd0, 8'h85, 4'd9}, '{2'd2, 8'h5F, 4'd9},          // R9 routed read
    '{2'd0, 8'h07, 4'd9}, '{2'd1, 8'h05, 4'd9},
    '{2'd0, 8'h85, 4'd9}, '{2'd2, 8'hFF, 4'd9},          // R9 not routed
    '{2'd0, 8'hAA, 4'd4}, '{2'd2, 8'hFF, 4'd4},          // R4 relock
    '{2'd3, 8'hFF, 4'd11},
    '{2'd1, 8'h11, 4'd5}                                 // R5 locked write
  };

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdp(DAT, rd); chk(rd, 8'hFF, "R1");
    rdp(IDX, rd); chk(rd, 8'hFF, "R1");

    for (int i = 0; i < NV; i++) begin
      unique case (VEC[i].op)
        2'd0: wr(IDX, VEC[i].val);
        2'd1: wr(DAT, VEC[i].val);
        2'd2: begin rdp(DAT, rd); chk(rd, VEC[i].val, $sformatf("R%0d", VEC[i].req)); end
        default: begin rdp(IDX, rd); chk(rd, VEC[i].val, $sformatf("R%0d", VEC[i].req)); end
      endcase
    end

    // R5: locked writes leave the device number (0x05) alone and raise no strobe
    cnt0 = bank_wr_cnt;
    wr(IDX, 8'h07); wr(DAT, 8'h09);
    wr(IDX, 8'h87); wr(IDX, 8'h87); wr(IDX, 8'h07);
    rdp(DAT, rd); chk(rd, 8'h05, "R5");
    chk(8'(bank_wr_cnt - cnt0), 8'h00, "R5");

    // R4: lock byte does not overwrite the index
    wr(IDX, 8'hAA); wr(IDX, 8'h87); wr(IDX, 8'h87);
    rdp(IDX, rd); chk(rd, 8'h07, "R4");
    wr(IDX, 8'hAA);

    // R2: a single key byte is not enough
    wr(IDX, 8'h87); wr(IDX, 8'h07);
    rdp(DAT, rd); chk(rd, 8'hFF, "R2");

    // R3: broken pair restarts the sequence
    wr(IDX, 8'h87); wr(IDX, 8'h55); wr(IDX, 8'h87); wr(IDX, 8'h07);
    rdp(DAT, rd); chk(rd, 8'hFF, "R3");
    rdp(IDX, rd); chk(rd, 8'hFF, "R3");

    // R10: keys at the other base do nothing
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87); wr(IDX, 8'h07);
    rdp(DAT, rd); chk(rd, 8'hFF, "R10");
    rdp(16'h004F, rd); chk(rd, 8'hFF, "R10");

    // R9: bank write with GPIO device selected
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    wr(IDX, 8'h07); wr(DAT, 8'h06);
    cnt0 = bank_wr_cnt;
    wr(IDX, 8'h90); wr(DAT, 8'hC3);
    chk(8'(bank_wr_cnt - cnt0), 8'h01, "R9");
    chk({1'b0, last_baddr}, 8'h10, "R9");
    chk(last_bdata, 8'hC3, "R9");
    // R9: no bank write with another device
    wr(IDX, 8'h07); wr(DAT, 8'h05);
    cnt0 = bank_wr_cnt;
    wr(IDX, 8'h90); wr(DAT, 8'h44);
    chk(8'(bank_wr_cnt - cnt0), 8'h00, "R9");

    // R1: reset while open relocks and clears selection
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rdp(DAT, rd); chk(rd, 8'hFF, "R1");
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    rdp(IDX, rd); chk(rd, 8'h00, "R1");
    wr(IDX, 8'h07);
    rdp(DAT, rd); chk(rd, 8'h00, "R1");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule